// File: doc/BRIEF.md
# Serial-Loaded Mapper Register File

This block sits on the CPU write bus of a cartridge-style memory controller and holds four 5-bit configuration registers: a control register, two graphics bank registers and a program bank register. The CPU cannot write a register in one access. It builds each value one bit at a time. Every write into the upper half of the 16-bit address space contributes data bit 0 to a shift buffer, least significant bit first. The fifth accepted bit commits the assembled value to the register that address bits 14:13 of that fifth write select.

A write with data bit 7 set is a reset command. It abandons any partial value and forces two mode bits of the control register high. A read-modify-write instruction issues two writes on consecutive cycles. To absorb the second of these, the block ignores every write that arrives in the cycle directly after an accepted reset command. Each commit and each accepted reset command raises a one-cycle update strobe that carries the index of the register that changed, so that downstream address-translation logic can recompute its mappings.

The write port is a plain strobe. A CPU bus cannot stall, so the block offers no back-pressure: every strobed write is either consumed or dropped in the same cycle, and there is no ready signal.

Top module: `smr_serial_regfile`

## Requirements
- R1: A write affects nothing unless `wr_en` is 1 and address bit 15 is 1. Writes to 0x0000–0x7FFF and cycles with `wr_en` low leave every register, the buffer and the strobe unchanged.
- R2: An accepted write with data bit 7 set clears the shift buffer and its bit count. It ORs 0b01100 into the control register, so control bits 3:2 become 1 and bits 4, 1 and 0 keep their values.
- R3: An accepted write with data bit 7 clear shifts data bit 0 into the buffer. The first bit of a sequence lands in bit 0 of the value and the fifth lands in bit 4. Data bits 1 to 6 have no effect.
- R4: The fifth accepted shift write copies the 5-bit value into the register that its own address bits 14:13 select: 00 control, 01 bank 0, 10 bank 1, 11 program bank. Addresses of the earlier four writes do not matter. The buffer then restarts empty.
- R5: Any write (shift or reset command) in the cycle right after an accepted reset command is ignored. Writes two or more cycles after it are accepted.
- R6: After reset the control register is 0x1F, the other registers are 0, the buffer is empty, the update strobe is low and the write guard is open.
- R7: `upd_vld` is high for exactly the one cycle after an edge at which a commit or an accepted reset command occurred. `upd_idx` then gives the register changed (0 for a reset command). In all other cycles the registers hold their values.
- R8: A reset command accepted partway through a sequence discards the bits gathered so far. The next five accepted shift writes form a fresh value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU address |
| wr_data | input | 8 | CPU write data |
| ctrl_q | output | 5 | Control register |
| bank0_q | output | 5 | Graphics bank 0 register |
| bank1_q | output | 5 | Graphics bank 1 register |
| prg_q | output | 5 | Program bank register |
| upd_vld | output | 1 | One-cycle pulse after a register changed |
| upd_idx | output | 2 | Index of the changed register while `upd_vld` is high |

## Verification
The assertions assume that each CPU write occupies one cycle of `wr_en` and that address and data are stable for that cycle. They also assume that reset is held for at least one clock edge. No assumption is made about how closely writes follow one another. The stimulus drives inputs only at falling edges and holds them for a full cycle. It mixes dense back-to-back writes, low-address writes and occasional reset commands, so the guard window, partial sequences cut short by a reset, and commits to every register index all occur.

// File: rtl/smr_pkg.sv
package smr_pkg;
  localparam int SEL_W    = 2;
  localparam int NUM_REGS = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BANK0 = 2'd1,
    SEL_BANK1 = 2'd2,
    SEL_PRG   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/smr_guard.sv
// Counts cycles elapsed since the last accepted reset command; saturates.
module smr_guard #(
  parameter int GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_cmd_i,
  output logic open_o
);
  localparam int CW = $clog2(GUARD_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(GUARD_CYC);

  logic [CW-1:0] elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= SAT;
    end else if (rst_cmd_i) begin
      elapsed <= CW'(1);
    end else if (elapsed < SAT) begin
      elapsed <= elapsed + CW'(1);
    end
  end

  assign open_o = (elapsed >= SAT);
endmodule

// File: rtl/smr_decode.sv
// Qualifies a CPU write and splits it into reset command or shift bit.
module smr_decode #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              open_i,
  output logic              rst_cmd_o,
  output logic              shift_o,
  output logic              bit_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic hit;

  assign hit       = wr_en_i && addr_i[ADDR_W-1] && open_i;
  assign rst_cmd_o = hit &&  data_i[DATA_W-1];
  assign shift_o   = hit && !data_i[DATA_W-1];
  assign bit_o     = data_i[0];
  assign sel_o     = addr_i[ADDR_W-2 -: SEL_W];
endmodule

// File: rtl/smr_shifter.sv
// Assembles a value LSB first; flags the write that completes it.
module smr_shifter #(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             clear_i,
  output logic             commit_o,
  output logic [VAL_W-1:0] value_o,
  output logic [$clog2(VAL_W)-1:0] count_o
);
  localparam int CW = $clog2(VAL_W);
  localparam logic [CW-1:0] LAST = CW'(VAL_W - 1);

  logic [VAL_W-1:0] buf_q;
  logic [VAL_W-1:0] buf_nxt;
  logic [CW-1:0]    cnt_q;

  for (genvar k = 0; k < VAL_W; k++) begin : g_bit
    assign buf_nxt[k] = (cnt_q == CW'(k)) ? bit_i : buf_q[k];
  end

  assign commit_o = shift_i && (cnt_q == LAST);
  assign value_o  = buf_nxt;
  assign count_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (clear_i || commit_o) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      buf_q <= buf_nxt;
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/smr_regbank.sv
// Holds the register array and produces the registered update strobe.
module smr_regbank #(
  parameter int              VAL_W       = 5,
  parameter int              SEL_W       = 2,
  parameter logic [VAL_W-1:0] CTRL_INIT   = 5'h1F,
  parameter logic [VAL_W-1:0] CTRL_RST_OR = 5'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [VAL_W-1:0] value_i,
  input  logic             rst_cmd_i,
  output logic [VAL_W-1:0] regs_o [1<<SEL_W],
  output logic             upd_vld_o,
  output logic [SEL_W-1:0] upd_idx_o
);
  localparam int NREG = 1 << SEL_W;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [VAL_W-1:0] INIT = (i == 0) ? CTRL_INIT : '0;
    logic [VAL_W-1:0] q;
    logic             wr_hit;

    assign wr_hit = commit_i && (sel_i == SEL_W'(i));

    if (i == 0) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= INIT;
        else if (rst_cmd_i) q <= q | CTRL_RST_OR;
        else if (wr_hit)    q <= value_i;
      end
    end else begin : g_data
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= INIT;
        else if (wr_hit) q <= value_i;
      end
    end

    assign regs_o[i] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_vld_o <= 1'b0;
      upd_idx_o <= '0;
    end else begin
      upd_vld_o <= commit_i || rst_cmd_i;
      upd_idx_o <= rst_cmd_i ? '0 : (commit_i ? sel_i : upd_idx_o);
    end
  end
endmodule

// File: rtl/smr_serial_regfile.sv
module smr_serial_regfile
  import smr_pkg::*;
#(
  parameter int               ADDR_W      = 16,
  parameter int               DATA_W      = 8,
  parameter int               VAL_W       = 5,
  parameter int               GUARD_CYC   = 2,
  parameter logic [VAL_W-1:0] CTRL_INIT   = 5'h1F,
  parameter logic [VAL_W-1:0] CTRL_RST_OR = 5'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VAL_W-1:0]  ctrl_q,
  output logic [VAL_W-1:0]  bank0_q,
  output logic [VAL_W-1:0]  bank1_q,
  output logic [VAL_W-1:0]  prg_q,
  output logic              upd_vld,
  output logic [SEL_W-1:0]  upd_idx
);
  logic             guard_open;
  logic             acc_rst;
  logic             acc_shift;
  logic             shift_bit;
  logic [SEL_W-1:0] sel;
  logic             commit;
  logic [VAL_W-1:0] value;
  logic [$clog2(VAL_W)-1:0] shf_cnt;
  logic [VAL_W-1:0] regs [NUM_REGS];

  smr_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk(clk), .rst_n(rst_n), .rst_cmd_i(acc_rst), .open_o(guard_open)
  );

  smr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_decode (
    .wr_en_i(wr_en), .addr_i(wr_addr), .data_i(wr_data), .open_i(guard_open),
    .rst_cmd_o(acc_rst), .shift_o(acc_shift), .bit_o(shift_bit), .sel_o(sel)
  );

  smr_shifter #(.VAL_W(VAL_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_i(acc_shift), .bit_i(shift_bit),
    .clear_i(acc_rst), .commit_o(commit), .value_o(value), .count_o(shf_cnt)
  );

  smr_regbank #(
    .VAL_W(VAL_W), .SEL_W(SEL_W),
    .CTRL_INIT(CTRL_INIT), .CTRL_RST_OR(CTRL_RST_OR)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .sel_i(sel),
    .value_i(value), .rst_cmd_i(acc_rst), .regs_o(regs),
    .upd_vld_o(upd_vld), .upd_idx_o(upd_idx)
  );

  assign ctrl_q  = regs[SEL_CTRL];
  assign bank0_q = regs[SEL_BANK0];
  assign bank1_q = regs[SEL_BANK1];
  assign prg_q   = regs[SEL_PRG];
endmodule

// File: rtl/smr_checker.sv
module smr_checker #(
  parameter int               ADDR_W      = 16,
  parameter int               VAL_W       = 5,
  parameter logic [VAL_W-1:0] CTRL_RST_OR = 5'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [VAL_W-1:0]  ctrl_q,
  input logic [VAL_W-1:0]  bank0_q,
  input logic [VAL_W-1:0]  bank1_q,
  input logic [VAL_W-1:0]  prg_q,
  input logic              upd_vld,
  input logic              acc_rst,
  input logic              acc_shift,
  input logic              commit,
  input logic [$clog2(VAL_W)-1:0] shf_cnt
);
  p_ignore_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr[ADDR_W-1]) |=> !upd_vld);

  p_ctrl_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rst |=> ((ctrl_q & CTRL_RST_OR) == CTRL_RST_OR) &&
                ((ctrl_q & ~CTRL_RST_OR) == ($past(ctrl_q) & ~CTRL_RST_OR)));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(shf_cnt) < VAL_W);

  p_commit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (shf_cnt == '0));

  p_guard_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rst |=> !(acc_rst || acc_shift));

  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |-> (ctrl_q == $past(ctrl_q)) && (bank0_q == $past(bank0_q)) &&
                 (bank1_q == $past(bank1_q)) && (prg_q == $past(prg_q)));

  p_partial_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rst |=> (shf_cnt == '0));
endmodule

bind smr_serial_regfile smr_checker #(
  .ADDR_W(ADDR_W), .VAL_W(VAL_W), .CTRL_RST_OR(CTRL_RST_OR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .ctrl_q(ctrl_q), .bank0_q(bank0_q), .bank1_q(bank1_q), .prg_q(prg_q),
  .upd_vld(upd_vld), .acc_rst(acc_rst), .acc_shift(acc_shift),
  .commit(commit), .shf_cnt(shf_cnt)
);

// File: tb/smr_serial_regfile_bench.sv
module smr_serial_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0]  ctrl_q, bank0_q, bank1_q, prg_q;
  logic        upd_vld;
  logic [1:0]  upd_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state
  logic [4:0] m_reg [4];
  logic [4:0] m_buf;
  int         m_cnt;
  int         m_guard;
  logic       m_vld;
  logic [1:0] m_idx;

  always #2 clk = ~clk;

  smr_serial_regfile u_smr_serial_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .bank0_q(bank0_q),
    .bank1_q(bank1_q), .prg_q(prg_q), .upd_vld(upd_vld), .upd_idx(upd_idx)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ins_bit(logic [4:0] b, int pos, logic v);
    logic [4:0] r = b;
    r[pos] = v;
    return r;
  endfunction

  task automatic model_reset();
    m_reg[0] = 5'h1F; m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
    m_buf = '0; m_cnt = 0; m_guard = 2; m_vld = 1'b0; m_idx = '0;
  endtask

  task automatic compare_all(string req);
    chk(req, "ctrl", 32'(ctrl_q), 32'(m_reg[0]));
    chk(req, "bank0", 32'(bank0_q), 32'(m_reg[1]));
    chk(req, "bank1", 32'(bank1_q), 32'(m_reg[2]));
    chk(req, "prg", 32'(prg_q), 32'(m_reg[3]));
    chk(req, "upd_vld", 32'(upd_vld), 32'(m_vld));
    if (m_vld) chk(req, "upd_idx", 32'(upd_idx), 32'(m_idx));
  endtask

  // one CPU cycle: drive, advance model, check after the edge
  task automatic step(bit we, logic [15:0] a, logic [7:0] d, string req);
    bit ok;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    ok = we && a[15] && (m_guard >= 2);
    m_vld = 1'b0;
    if (ok && d[7]) begin
      m_reg[0] = m_reg[0] | 5'h0C;
      m_buf = '0; m_cnt = 0; m_guard = 1;
      m_vld = 1'b1; m_idx = 2'd0;
    end else begin
      if (m_guard < 2) m_guard++;
      if (ok) begin
        m_buf = ins_bit(m_buf, m_cnt, d[0]);
        m_cnt++;
        if (m_cnt == 5) begin
          m_reg[a[14:13]] = m_buf;
          m_vld = 1'b1; m_idx = a[14:13];
          m_buf = '0; m_cnt = 0;
        end
      end
    end
    @(posedge clk);
    #1;
    compare_all(req);
  endtask

  task automatic load(logic [4:0] v, logic [1:0] sel, string req);
    for (int i = 0; i < 5; i++)
      step(1'b1, {1'b1, sel, 13'h0123}, {7'h3A, v[i]}, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare_all("R6");

    // R3/R4: LSB-first load to each register, noise in data bits 1..6
    load(5'h16, 2'd3, "R3");
    load(5'h09, 2'd1, "R4");
    load(5'h1B, 2'd2, "R4");
    load(5'h05, 2'd0, "R4");

    // R4: only fifth write's address selects the target
    step(1'b1, 16'h8000, 8'h01, "R4");
    step(1'b1, 16'hA000, 8'h00, "R4");
    step(1'b1, 16'hC000, 8'h01, "R4");
    step(1'b1, 16'h8000, 8'h01, "R4");
    step(1'b1, 16'hE000, 8'h00, "R4");
    chk("R4", "prg fifth-address", 32'(prg_q), 32'h0D);

    // R1: low addresses and idle strobe are ignored mid-sequence
    step(1'b1, 16'h8000, 8'h01, "R1");
    step(1'b1, 16'h7FFF, 8'h80, "R1");
    step(1'b0, 16'hFFFF, 8'h80, "R1");
    step(1'b1, 16'h0000, 8'h01, "R1");
    for (int i = 0; i < 4; i++) step(1'b1, 16'hA000, 8'h00, "R1");
    chk("R1", "bank0 after ignored writes", 32'(bank0_q), 32'h01);

    // R8 + R2: reset command mid-sequence discards bits
    step(1'b1, 16'hC000, 8'h01, "R8");
    step(1'b1, 16'hC000, 8'h01, "R8");
    step(1'b1, 16'hFFFF, 8'h80, "R2");
    chk("R2", "ctrl forced", 32'(ctrl_q), 32'h0D);
    // R5: write one cycle later ignored (both kinds), then accepted
    step(1'b1, 16'hC000, 8'h00, "R5");
    chk("R5", "strobe after guarded write", 32'(upd_vld), 32'h0);
    load(5'h12, 2'd2, "R8");
    chk("R8", "bank1 fresh value", 32'(bank1_q), 32'h12);
    step(1'b1, 16'h8000, 8'h80, "R2");
    step(1'b1, 16'h8000, 8'h80, "R5");
    step(1'b1, 16'h8000, 8'h80, "R5");
    chk("R5", "reset cmd two cycles later accepted", 32'(upd_vld), 32'h1);

    // random mix, all cycles checked against the model (R7)
    for (int c = 0; c < 4000; c++) begin
      bit we = ($urandom_range(0, 9) < 7);
      logic [15:0] a = 16'($urandom());
      logic [7:0]  d = 8'($urandom());
      if ($urandom_range(0, 9) < 8) a[15] = 1'b1;
      d[7] = ($urandom_range(0, 19) == 0);
      step(we, a, d, "R7");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule